// File: doc/BRIEF.md
# Gated prescaled period timer

This block is an up-counter that steps on prescaled events and wraps against a programmable period. Each wrap latches an event flag, which can also raise an interrupt line. Count events come from one of two places. The first is a per-cycle instruction-clock enable, which can be qualified by a gate input so that the counter accumulates high time only. The second is an external clock input, taken either raw as a per-cycle enable or through a synchronizer with rising-edge detection. Everything runs in one main clock domain.

Software reaches the block through a write-only port with a 2-bit address. Address 0 is control, 1 is the count, 2 is the period and 3 is status. The count, the flag and the interrupt are visible as outputs. Two strobes, idle and sleep, describe the low-power state of the host. The control fields decide whether counting continues while either strobe is high.

Control layout, bit 0 first:
- run enable
- external source select
- external sync enable
- gate mode
- two prescale bits
- stop-in-idle
- interrupt enable

Top module: `gated_period_timer`

## Requirements
- R1: After reset the count is 0, the flag is 0, the interrupt is 0 and the period is all ones.
- R2: Control bits [5:4] set the prescale ratio: 0 gives 1:1, 1 gives 1:8, 2 gives 1:64 and 3 gives 1:256. The counter steps once per that many qualified source events.
- R3: On a prescaled step with the count equal to the period, the count becomes 0 and the flag sets. Otherwise the count increments by one.
- R4: With a period of 0, the count stays 0 and every prescaled step sets the flag.
- R5: With gate mode (ctrl[3]) set and the internal source selected (ctrl[1]=0), only cycles with both tcy_en and gate_i high are source events.
- R6: With the external source selected, gate_i has no effect even when gate mode is set.
- R7: In external mode with ctrl[2]=0, every cycle with ext_clk_i high is one event. With ctrl[2]=1, each rising edge of ext_clk_i yields exactly one event, however long the input stays high.
- R8: The prescaler clears when the count is written while running, and when a control write drops run enable (ctrl[0]) from 1 to 0. While run enable is 0, neither the count nor the prescaler moves.
- R9: A count write (address 1) loads the count and wins over a step in the same cycle. A control write leaves the count unchanged.
- R10: While idle_i is high and ctrl[6] is 1, counting pauses and resumes from the same state afterwards. With ctrl[6]=0, counting continues through idle.
- R11: While sleep_i is high, counting continues only with the external source selected and ctrl[2]=0.
- R12: The flag stays set until a status write (address 3) with data bit 0 set. irq_o equals the flag ANDed with ctrl[7].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tcy_en | input | 1 | Internal instruction-clock enable, one event per high cycle |
| ext_clk_i | input | 1 | External clock input |
| gate_i | input | 1 | Gate level for accumulation mode |
| idle_i | input | 1 | Host idle strobe |
| sleep_i | input | 1 | Host sleep strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 count, 2 period, 3 status |
| wr_data | input | CNT_W | Write data |
| count_o | output | CNT_W | Current count |
| flag_o | output | 1 | Sticky period-match flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is a prescaler holding a partial count at the moment it is cleared or frozen. The effect only shows several events later, as a step that arrives early or late. The stimulus leaves the prescaler part-way through a 1:8 cycle and then writes the count, drops run enable, or holds idle or sleep. It then applies just enough events to expose a missing or spurious clear. Random trials pick the ratio, a short period and an event count, so the wrap and the flag fall at varied phases. A directed case writes the count while the instruction enable stays high, which makes the write collide with an increment.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

   typedef enum logic [1:0] {
      REG_CTRL   = 2'd0,
      REG_COUNT  = 2'd1,
      REG_PERIOD = 2'd2,
      REG_STATUS = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic       irq_en;     // bit 7
      logic       idle_stop;  // bit 6
      logic [1:0] ps_sel;     // bits 5:4
      logic       gate_mode;  // bit 3
      logic       sync_ext;   // bit 2
      logic       src_ext;    // bit 1
      logic       run_en;     // bit 0
   } ctrl_t;

   localparam int unsigned CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/gpt_src_sel.sv
module gpt_src_sel #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          HAS_SYNC    = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tcy_en,
   input  logic ext_clk_i,
   input  logic gate_i,
   input  logic src_ext,
   input  logic sync_ext,
   input  logic gate_mode,
   output logic src_evt
);

   logic sync_pulse;

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("gpt_src_sel: SYNC_STAGES must be at least 2");
   end

   if (HAS_SYNC) begin : g_sync
      // synchronizer stages plus one extra flop for edge detection
      logic [SYNC_STAGES:0] sh_q;
      always_ff @(posedge clk) begin
         if (!rst_n) sh_q <= '0;
         else        sh_q <= {sh_q[SYNC_STAGES-1:0], ext_clk_i};
      end
      assign sync_pulse = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];

      a_r7_one_cycle_pulse : assert property (@(posedge clk) disable iff (!rst_n)
         sync_pulse |=> !sync_pulse);
   end else begin : g_nosync
      assign sync_pulse = ext_clk_i;
   end

   always_comb begin
      if (src_ext) src_evt = sync_ext ? sync_pulse : ext_clk_i;
      else         src_evt = tcy_en & (~gate_mode | gate_i);
   end

endmodule

// File: rtl/gpt_prescaler.sv
module gpt_prescaler #(
   parameter int unsigned PS_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            adv,
   input  logic            clr,
   input  logic [1:0]      sel,
   output logic            tick
);

   logic [PS_W-1:0] pcnt_q;
   logic [PS_W-1:0] last_val;

   if (PS_W < 8) begin : g_bad_width
      $error("gpt_prescaler: PS_W must hold a 1:256 ratio");
   end

   always_comb begin
      case (sel)
         2'd0:    last_val = '0;
         2'd1:    last_val = PS_W'(7);
         2'd2:    last_val = PS_W'(63);
         default: last_val = PS_W'(255);
      endcase
   end

   assign tick = adv & (pcnt_q == last_val);

   always_ff @(posedge clk) begin
      if (!rst_n)   pcnt_q <= '0;
      else if (clr) pcnt_q <= '0;
      else if (adv) pcnt_q <= tick ? '0 : pcnt_q + 1'b1;
   end

   a_r8_prescaler_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !clr) |=> $stable(pcnt_q));

   a_r8_prescaler_clear : assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (pcnt_q == '0));

endmodule

// File: rtl/gpt_counter.sv
module gpt_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             ld,
   input  logic [CNT_W-1:0] ld_val,
   input  logic [CNT_W-1:0] period,
   input  logic             flag_clr,
   output logic [CNT_W-1:0] cnt,
   output logic             flag
);

   logic match;
   assign match = (cnt == period);

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt <= '0;
      else if (ld)   cnt <= ld_val;
      else if (tick) cnt <= match ? '0 : cnt + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                    flag <= 1'b0;
      else if (tick && match && !ld) flag <= 1'b1;
      else if (flag_clr)             flag <= 1'b0;
   end

   a_r3_wrap_sets_flag : assert property (@(posedge clk) disable iff (!rst_n)
      (tick && match && !ld) |=> (cnt == '0) && flag);

   a_r3_no_step_holds : assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !ld) |=> $stable(cnt));

   a_r9_load_wins : assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (cnt == $past(ld_val)));

   a_r12_flag_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !flag_clr) |=> flag);

endmodule

// File: rtl/gated_period_timer.sv
module gated_period_timer
   import gpt_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned PS_W        = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          HAS_SYNC    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tcy_en,
   input  logic             ext_clk_i,
   input  logic             gate_i,
   input  logic             idle_i,
   input  logic             sleep_i,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] count_o,
   output logic             flag_o,
   output logic             irq_o
);

   if (CNT_W < CTRL_W) begin : g_bad_cnt_w
      $error("gated_period_timer: CNT_W must cover the control word");
   end

   ctrl_t            ctrl_q;
   ctrl_t            ctrl_new;
   logic [CNT_W-1:0] period_q;
   logic             wr_ctrl, wr_cnt, wr_per, wr_stat;
   logic             running, src_evt, adv, ps_clr, tick;

   assign wr_ctrl  = wr_en && (wr_addr == REG_CTRL);
   assign wr_cnt   = wr_en && (wr_addr == REG_COUNT);
   assign wr_per   = wr_en && (wr_addr == REG_PERIOD);
   assign wr_stat  = wr_en && (wr_addr == REG_STATUS);
   assign ctrl_new = ctrl_t'(wr_data[CTRL_W-1:0]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         period_q <= '1;
      end else begin
         if (wr_ctrl) ctrl_q   <= ctrl_new;
         if (wr_per)  period_q <= wr_data;
      end
   end

   // sleep keeps only the unsynchronized external path alive
   assign running = ctrl_q.run_en
                  & ~(idle_i & ctrl_q.idle_stop)
                  & ~(sleep_i & ~(ctrl_q.src_ext & ~ctrl_q.sync_ext));

   // prescaler clock is stopped while disabled, so clears need run_en
   assign ps_clr = ctrl_q.run_en & (wr_cnt | (wr_ctrl & ~ctrl_new.run_en));

   gpt_src_sel #(
      .SYNC_STAGES (SYNC_STAGES),
      .HAS_SYNC    (HAS_SYNC)
   ) src_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .tcy_en    (tcy_en),
      .ext_clk_i (ext_clk_i),
      .gate_i    (gate_i),
      .src_ext   (ctrl_q.src_ext),
      .sync_ext  (ctrl_q.sync_ext),
      .gate_mode (ctrl_q.gate_mode),
      .src_evt   (src_evt)
   );

   assign adv = src_evt & running;

   gpt_prescaler #(
      .PS_W (PS_W)
   ) ps_i (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (adv),
      .clr   (ps_clr),
      .sel   (ctrl_q.ps_sel),
      .tick  (tick)
   );

   gpt_counter #(
      .CNT_W (CNT_W)
   ) cnt_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .ld       (wr_cnt),
      .ld_val   (wr_data),
      .period   (period_q),
      .flag_clr (wr_stat & wr_data[0]),
      .cnt      (count_o),
      .flag     (flag_o)
   );

   assign irq_o = flag_o & ctrl_q.irq_en;

   a_r12_irq_needs_flag : assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> flag_o);

   a_r11_sleep_internal_frozen : assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_i && !ctrl_q.src_ext && !wr_cnt) |=> $stable(count_o));

   a_r8_disabled_frozen : assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q.run_en && !wr_cnt) |=> $stable(count_o));

endmodule

// File: tb/gated_period_timer_tb_top.sv
`timescale 1ns/1ps
module gated_period_timer_tb_top;

   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tcy_en = 1'b0, ext_clk_i = 1'b0, gate_i = 1'b0;
   logic         idle_i = 1'b0, sleep_i = 1'b0;
   logic         wr_en = 1'b0;
   logic [1:0]   wr_addr = 2'd0;
   logic [W-1:0] wr_data = '0;
   logic [W-1:0] count_o;
   logic         flag_o, irq_o;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   gated_period_timer dut_i (
      .clk (clk), .rst_n (rst_n), .tcy_en (tcy_en), .ext_clk_i (ext_clk_i),
      .gate_i (gate_i), .idle_i (idle_i), .sleep_i (sleep_i), .wr_en (wr_en),
      .wr_addr (wr_addr), .wr_data (wr_data), .count_o (count_o),
      .flag_o (flag_o), .irq_o (irq_o)
   );

   function automatic logic [W-1:0] mk_ctrl(bit run, bit ext, bit syn, bit gate,
                                            int sel, bit stop, bit ien);
      logic [W-1:0] v = '0;
      v[0] = run; v[1] = ext; v[2] = syn; v[3] = gate;
      v[5:4] = 2'(sel); v[6] = stop; v[7] = ien;
      return v;
   endfunction

   function automatic int ratio_of(int sel);
      case (sel)
         0: return 1;
         1: return 8;
         2: return 64;
         default: return 256;
      endcase
   endfunction

   function automatic int exp_count(int n, int sel, int per);
      return (n / ratio_of(sel)) % (per + 1);
   endfunction

   function automatic bit exp_flag(int n, int sel, int per);
      return (n / ratio_of(sel)) > per;
   endfunction

   task automatic chk(string req, int act, int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(int addr, logic [W-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 2'(addr); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulses(int n);
      tcy_en = 1'b1;
      repeat (n) @(negedge clk);
      tcy_en = 1'b0;
   endtask

   task automatic ext_level(int n);
      ext_clk_i = 1'b1;
      repeat (n) @(negedge clk);
      ext_clk_i = 1'b0;
   endtask

   task automatic ext_edges(int k);
      for (int i = 0; i < k; i++) begin
         ext_clk_i = 1'b1;
         repeat (3) @(negedge clk);
         ext_clk_i = 1'b0;
         repeat (3) @(negedge clk);
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic setup(logic [W-1:0] ctrl, int per);
      wr(0, '0);
      wr(2, W'(per));
      wr(1, '0);
      wr(3, W'(1));
      wr(0, ctrl);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state, period all ones: 5 steps do not wrap
      chk("R1 count", int'(count_o), 0);
      chk("R1 flag", int'(flag_o), 0);
      chk("R1 irq", int'(irq_o), 0);
      wr(0, mk_ctrl(1, 0, 0, 0, 0, 0, 0));
      pulses(5);
      chk("R1 period ones", int'(count_o), 5);

      // R2 R3 random ratio, period and event count
      for (int it = 0; it < 14; it++) begin
         int sel = int'($urandom % 4);
         int per = int'($urandom % 6);
         int n   = int'($urandom % (ratio_of(sel) * (per + 1) * 2 + 1));
         bit ien = 1'($urandom % 2);
         setup(mk_ctrl(1, 0, 0, 0, sel, 0, ien), per);
         pulses(n);
         chk("R2 R3 count", int'(count_o), exp_count(n, sel, per));
         chk("R3 flag", int'(flag_o), int'(exp_flag(n, sel, per)));
         chk("R12 irq", int'(irq_o), int'(exp_flag(n, sel, per) & ien));
      end

      // R4 period zero
      setup(mk_ctrl(1, 0, 0, 0, 0, 0, 1), 0);
      pulses(3);
      chk("R4 count", int'(count_o), 0);
      chk("R4 flag", int'(flag_o), 1);
      // R12 write-one-to-clear
      wr(3, '0);
      chk("R12 w0 keeps flag", int'(flag_o), 1);
      chk("R12 irq on", int'(irq_o), 1);
      wr(0, mk_ctrl(1, 0, 0, 0, 0, 0, 0));
      chk("R12 irq masked", int'(irq_o), 0);
      wr(3, W'(1));
      chk("R12 w1 clears", int'(flag_o), 0);

      // R5 gated accumulation, random gate pattern
      begin
         int expn = 0;
         setup(mk_ctrl(1, 0, 0, 1, 0, 0, 0), 16'hFFFF);
         for (int c = 0; c < 200; c++) begin
            tcy_en = 1'($urandom % 2);
            gate_i = 1'($urandom % 2);
            if (tcy_en && gate_i) expn++;
            @(negedge clk);
         end
         tcy_en = 1'b0; gate_i = 1'b0;
         chk("R5 gated count", int'(count_o), expn);
      end

      // R6 gate ignored with external source
      setup(mk_ctrl(1, 1, 0, 1, 0, 0, 0), 16'hFFFF);
      gate_i = 1'b0;
      ext_level(5);
      chk("R6 gate ignored", int'(count_o), 5);

      // R7 raw external level and synchronized edges
      setup(mk_ctrl(1, 1, 0, 0, 0, 0, 0), 16'hFFFF);
      ext_level(7);
      chk("R7 raw level", int'(count_o), 7);
      setup(mk_ctrl(1, 1, 1, 0, 0, 0, 0), 16'hFFFF);
      ext_edges(4);
      chk("R7 sync edges", int'(count_o), 4);
      ext_level(20);
      repeat (4) @(negedge clk);
      chk("R7 long high one edge", int'(count_o), 5);

      // R8 prescaler clear on count write
      setup(mk_ctrl(1, 0, 0, 0, 1, 0, 0), 16'hFFFF);
      pulses(5);
      wr(1, '0);
      pulses(3);
      chk("R8 write clears prescaler", int'(count_o), 0);
      pulses(5);
      chk("R8 step after clear", int'(count_o), 1);
      // R8 disable clears and freezes
      pulses(5);
      wr(0, mk_ctrl(0, 0, 0, 0, 1, 0, 0));
      pulses(10);
      chk("R8 disabled frozen", int'(count_o), 1);
      wr(0, mk_ctrl(1, 0, 0, 0, 1, 0, 0));
      pulses(7);
      chk("R8 disable cleared prescaler", int'(count_o), 1);
      pulses(1);
      chk("R8 resumes", int'(count_o), 2);

      // R9 count write wins over step, control write keeps count
      setup(mk_ctrl(1, 0, 0, 0, 0, 0, 0), 16'hFFFF);
      @(negedge clk);
      tcy_en = 1'b1;
      repeat (3) @(negedge clk);
      wr_en = 1'b1; wr_addr = 2'd1; wr_data = 16'h1234;
      @(negedge clk);
      wr_en = 1'b0;
      chk("R9 load wins", int'(count_o), 16'h1234);
      @(negedge clk);
      tcy_en = 1'b0;
      chk("R9 step after load", int'(count_o), 16'h1235);
      wr(0, mk_ctrl(1, 0, 0, 0, 3, 1, 1));
      chk("R9 ctrl write keeps count", int'(count_o), 16'h1235);

      // R10 idle
      setup(mk_ctrl(1, 0, 0, 0, 1, 1, 0), 16'hFFFF);
      pulses(5);
      idle_i = 1'b1;
      pulses(20);
      chk("R10 idle stop", int'(count_o), 0);
      idle_i = 1'b0;
      pulses(3);
      chk("R10 resume keeps phase", int'(count_o), 1);
      wr(0, mk_ctrl(1, 0, 0, 0, 0, 0, 0));
      idle_i = 1'b1;
      pulses(4);
      idle_i = 1'b0;
      chk("R10 run through idle", int'(count_o), 5);

      // R11 sleep
      setup(mk_ctrl(1, 0, 0, 0, 0, 0, 0), 16'hFFFF);
      sleep_i = 1'b1;
      pulses(6);
      chk("R11 internal stops", int'(count_o), 0);
      wr(0, mk_ctrl(1, 1, 0, 0, 0, 0, 0));
      ext_level(6);
      chk("R11 raw external runs", int'(count_o), 6);
      wr(0, mk_ctrl(1, 1, 1, 0, 0, 0, 0));
      ext_edges(3);
      chk("R11 synced external stops", int'(count_o), 6);
      sleep_i = 1'b0;
      ext_edges(2);
      chk("R11 awake synced runs", int'(count_o), 8);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule